// File: doc/BRIEF.md
# Single-Bit ECC Fix-Up Engine

After a page or spare-area read has filled the internal page buffer, this block reads the ECC status word and the two error-position words and repairs any reported single-bit error in place. It does the repair through a 16-bit buffer RAM port as a read-modify-write. It decodes one 2-bit status field for the main area and one for the spare area, fixes at most one bit per area, and then reports the read as clean, corrected or uncorrectable. The ECC checker that produces the status and positions is outside this block.

A position word carries a halfword index above bit 4 and a bit index in bits [3:0]. The main area of buffer `b` holds halfwords `b*256 .. b*256+255`. The spare areas lie above all main areas, from word 1024, and spare area `b` begins at `1024 + b*8`. The sequencer is a six-state machine:
- `ST_IDLE` waits for `start`. On an accepted start it moves to `ST_MAIN_RD` if the main area needs a fix, otherwise to `ST_SPR_RD` if the spare area needs one, otherwise straight to `ST_FIN`.
- `ST_MAIN_RD` always moves to `ST_MAIN_WR`.
- `ST_MAIN_WR` moves to `ST_SPR_RD` if the spare area needs a fix, otherwise to `ST_FIN`.
- `ST_SPR_RD` always moves to `ST_SPR_WR`, and `ST_SPR_WR` always moves to `ST_FIN`.
- `ST_FIN` always returns to `ST_IDLE`.

Top module: `ecc_bit_fixer`

## Requirements
- R1: While reset is held and after it is released, `done`, `busy`, `ram_rd` and `ram_wr` are low until a start is accepted.
- R2: `ecc_stat[3:2]` is the main-area field and `ecc_stat[1:0]` is the spare-area field. In each field, 00 means no error and 01 means one correctable bit. 10 means an uncorrectable double error, and 11 is treated the same as 10.
- R3: A main fix targets word `buf_sel*256 + main_pos[11:4]`. A spare fix targets word `1024 + buf_sel*8 + spare_pos[6:4]`. Position bits above the index width are ignored, and the bit to toggle is `pos[3:0]`.
- R4: Each fix asserts `ram_rd` for one cycle and then, in the next cycle, asserts `ram_wr` at the same address. The written word equals the read word with exactly one bit inverted. The RAM returns read data one cycle after `ram_rd`.
- R5: When both fields request a fix, the main word is written first and the spare word second.
- R6: An area whose field is 10 or 11 gets no RAM access. The other area is still fixed if its field is 01.
- R7: When `spare_only` is high, the main field is ignored: there is no main access, and the field has no effect on the result.
- R8: `done` is a one-cycle pulse. It comes one cycle after the accepted start when nothing needs fixing, and otherwise one cycle after the last write. The total latency from start is 1, 3 or 5 cycles for 0, 1 or 2 fixes. `busy` is high from the cycle after an accepted start through the `done` cycle.
- R9: `result` is valid while `done` is high: 00 = clean, 01 = corrected, 10 = uncorrectable. An uncorrectable field in either area that counts gives 10, even if the other area was fixed.
- R10: `start` is ignored while `busy` is high. All inputs are sampled only on the accepted start, so later changes do not alter the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fix-up pass (accepted only when idle) |
| buf_sel | input | 2 | Buffer number of the read just completed |
| spare_only | input | 1 | Only the spare area was transferred |
| ecc_stat | input | 4 | Status: main field [3:2], spare field [1:0] |
| main_pos | input | 16 | Main-area error position (halfword index, bit index) |
| spare_pos | input | 16 | Spare-area error position (halfword index, bit index) |
| ram_addr | output | 11 | Buffer RAM halfword address |
| ram_rd | output | 1 | Buffer RAM read enable |
| ram_wr | output | 1 | Buffer RAM write enable |
| ram_wdata | output | 16 | Buffer RAM write data |
| ram_rdata | input | 16 | Buffer RAM read data, one cycle after `ram_rd` |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| result | output | 2 | Outcome code, valid with `done` |

## Verification
The bench targets the following corner cases:
- Both areas flagged at once. A design that skipped the second fix, or reversed the order, would produce a write log that differs from main-then-spare.
- One area uncorrectable while the other holds a single error. A design that gave up early would leave a bit unfixed. One that gave the uncorrectable field the wrong priority would return 01 instead of 10.
- Position words with stray high bits, and the last halfword of a slot. These expose address arithmetic that spills into a neighbouring buffer.
- A start pulse repeated while busy, and `spare_only` with a live main field. Either would show up as extra writes, a second `done`, or a wrong result.

// File: rtl/ecc_fix_pkg.sv
`timescale 1ns/1ps
package ecc_fix_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAIN_RD,
        ST_MAIN_WR,
        ST_SPR_RD,
        ST_SPR_WR,
        ST_FIN
    } fix_state_t;

    typedef enum logic [1:0] {
        RES_CLEAN  = 2'b00,
        RES_FIXED  = 2'b01,
        RES_UNCORR = 2'b10
    } fix_result_t;

    // Field value for a single correctable bit.
    localparam logic [1:0] FLD_ONE = 2'b01;

    // Codes 10 and 11 both mean the area cannot be repaired.
    function automatic logic fld_fatal(input logic [1:0] fld);
        return fld[1];
    endfunction

endpackage

// File: rtl/ecc_stat_decode.sv
`timescale 1ns/1ps
module ecc_stat_decode
    import ecc_fix_pkg::*;
(
    input  logic [3:0]  stat,
    input  logic        spare_only,
    output logic        fix_main,
    output logic        fix_spare,
    output fix_result_t verdict
);

    logic [1:0] main_fld;
    logic [1:0] spr_fld;
    logic       main_bad;
    logic       spr_bad;

    always_comb begin
        main_fld  = stat[3:2];
        spr_fld   = stat[1:0];
        // The main field only counts when the main area was transferred.
        fix_main  = !spare_only && (main_fld == FLD_ONE);
        fix_spare = (spr_fld == FLD_ONE);
        main_bad  = !spare_only && fld_fatal(main_fld);
        spr_bad   = fld_fatal(spr_fld);
        if (main_bad || spr_bad) begin
            verdict = RES_UNCORR;
        end else if (fix_main || fix_spare) begin
            verdict = RES_FIXED;
        end else begin
            verdict = RES_CLEAN;
        end
    end

endmodule

// File: rtl/ecc_slot_addr.sv
`timescale 1ns/1ps
module ecc_slot_addr #(
    parameter  int IDX_W      = 8,
    parameter  int SLOT_WORDS = 256,
    parameter  int BASE       = 0,
    parameter  int BUF_W      = 2,
    parameter  int ADDR_W     = 11,
    parameter  int POS_W      = 16,
    parameter  int DATA_W     = 16,
    localparam int BIT_W      = $clog2(DATA_W)
) (
    input  logic [BUF_W-1:0]  buf_sel,
    input  logic [POS_W-1:0]  pos,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] mask
);

    logic [IDX_W-1:0] idx;

    // The halfword index sits just above the bit index; bits beyond the slot are dropped.
    assign idx  = pos[BIT_W +: IDX_W];
    assign addr = ADDR_W'(BASE) + ADDR_W'(buf_sel) * ADDR_W'(SLOT_WORDS) + ADDR_W'(idx);
    assign mask = DATA_W'(1) << pos[BIT_W-1:0];

    generate
        if (BIT_W + IDX_W < POS_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^pos[POS_W-1:BIT_W+IDX_W];
        end
    endgenerate

endmodule

// File: rtl/ecc_bit_fixer.sv
`timescale 1ns/1ps
module ecc_bit_fixer
    import ecc_fix_pkg::*;
#(
    parameter  int BUF_CNT     = 4,
    parameter  int MAIN_WORDS  = 256,
    parameter  int SPARE_WORDS = 8,
    parameter  int DATA_W      = 16,
    parameter  int POS_W       = 16,
    localparam int BUF_W       = $clog2(BUF_CNT),
    localparam int SPARE_BASE  = MAIN_WORDS * BUF_CNT,
    localparam int TOTAL_WORDS = SPARE_BASE + SPARE_WORDS * BUF_CNT,
    localparam int ADDR_W      = $clog2(TOTAL_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BUF_W-1:0]  buf_sel,
    input  logic              spare_only,
    input  logic [3:0]        ecc_stat,
    input  logic [POS_W-1:0]  main_pos,
    input  logic [POS_W-1:0]  spare_pos,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);

    fix_state_t  state;
    fix_state_t  state_nx;

    logic              dec_fix_main;
    logic              dec_fix_spare;
    fix_result_t       dec_verdict;

    logic [BUF_W-1:0]  cap_buf;
    logic [POS_W-1:0]  cap_pos [2];
    logic              cap_fix_spare;
    fix_result_t       cap_result;

    logic [ADDR_W-1:0] area_addr [2];
    logic [DATA_W-1:0] area_mask [2];

    logic              take;

    assign take = (state == ST_IDLE) && start;

    ecc_stat_decode u_dec (
        .stat       (ecc_stat),
        .spare_only (spare_only),
        .fix_main   (dec_fix_main),
        .fix_spare  (dec_fix_spare),
        .verdict    (dec_verdict)
    );

    // One address/mask generator per area; index 0 = main, 1 = spare.
    generate
        for (genvar g = 0; g < 2; g++) begin : g_area
            localparam int IDX_W = (g == 0) ? $clog2(MAIN_WORDS) : $clog2(SPARE_WORDS);
            localparam int SLOT  = (g == 0) ? MAIN_WORDS : SPARE_WORDS;
            localparam int BASE  = (g == 0) ? 0 : SPARE_BASE;
            ecc_slot_addr #(
                .IDX_W      (IDX_W),
                .SLOT_WORDS (SLOT),
                .BASE       (BASE),
                .BUF_W      (BUF_W),
                .ADDR_W     (ADDR_W),
                .POS_W      (POS_W),
                .DATA_W     (DATA_W)
            ) u_addr (
                .buf_sel (cap_buf),
                .pos     (cap_pos[g]),
                .addr    (area_addr[g]),
                .mask    (area_mask[g])
            );
        end
    endgenerate

    // Operand capture on an accepted start only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_buf       <= '0;
            cap_pos[0]    <= '0;
            cap_pos[1]    <= '0;
            cap_fix_spare <= 1'b0;
            cap_result    <= RES_CLEAN;
        end else if (take) begin
            cap_buf       <= buf_sel;
            cap_pos[0]    <= main_pos;
            cap_pos[1]    <= spare_pos;
            cap_fix_spare <= dec_fix_spare;
            cap_result    <= dec_verdict;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (dec_fix_main) begin
                        state_nx = ST_MAIN_RD;
                    end else if (dec_fix_spare) begin
                        state_nx = ST_SPR_RD;
                    end else begin
                        state_nx = ST_FIN;
                    end
                end
            end
            ST_MAIN_RD: state_nx = ST_MAIN_WR;
            ST_MAIN_WR: state_nx = cap_fix_spare ? ST_SPR_RD : ST_FIN;
            ST_SPR_RD:  state_nx = ST_SPR_WR;
            ST_SPR_WR:  state_nx = ST_FIN;
            ST_FIN:     state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        ram_rd    = 1'b0;
        ram_wr    = 1'b0;
        done      = 1'b0;
        ram_addr  = area_addr[0];
        ram_wdata = ram_rdata ^ area_mask[0];
        unique case (state)
            ST_IDLE: begin
            end
            ST_MAIN_RD: begin
                ram_rd = 1'b1;
            end
            ST_MAIN_WR: begin
                ram_wr = 1'b1;
            end
            ST_SPR_RD: begin
                ram_rd   = 1'b1;
                ram_addr = area_addr[1];
            end
            ST_SPR_WR: begin
                ram_wr    = 1'b1;
                ram_addr  = area_addr[1];
                ram_wdata = ram_rdata ^ area_mask[1];
            end
            ST_FIN: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign busy   = (state != ST_IDLE);
    assign result = cap_result;

    // R4
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> ($past(ram_rd) && ram_addr == $past(ram_addr)));

    // R4
    one_bit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> $countones(ram_wdata ^ ram_rdata) == 1);

    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result != 2'b11);

    // R3
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd || ram_wr) |-> ram_addr < ADDR_W'(TOTAL_WORDS));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/sim_ecc_bit_fixer.sv
`timescale 1ns/1ps
module sim_ecc_bit_fixer;

    localparam int WORDS = 1056;

    typedef struct {
        logic [1:0] res;
        int         lat;
        int         t0;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  buf_sel = '0;
    logic        spare_only = 1'b0;
    logic [3:0]  ecc_stat = '0;
    logic [15:0] main_pos = '0;
    logic [15:0] spare_pos = '0;
    logic [10:0] ram_addr;
    logic        ram_rd;
    logic        ram_wr;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;
    logic        busy;
    logic        done;
    logic [1:0]  result;

    logic [15:0] mem     [WORDS];
    logic [15:0] exp_mem [WORDS];
    exp_t        sb [$];
    int          wlog [$];
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    ecc_bit_fixer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .buf_sel    (buf_sel),
        .spare_only (spare_only),
        .ecc_stat   (ecc_stat),
        .main_pos   (main_pos),
        .spare_pos  (spare_pos),
        .ram_addr   (ram_addr),
        .ram_rd     (ram_rd),
        .ram_wr     (ram_wr),
        .ram_wdata  (ram_wdata),
        .ram_rdata  (ram_rdata),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

    // Buffer RAM with one-cycle read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ram_wr) mem[ram_addr] <= ram_wdata;
        if (ram_rd) ram_rdata <= mem[ram_addr];
    end

    // Monitor: pops the scoreboard on each done, logs writes.
    always @(negedge clk) begin
        if (rst_n && ram_wr) wlog.push_back(int'(ram_addr));
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R10 unexpected done act=1 exp=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (result !== e.res) begin
                    bad++;
                    $display("FAIL R9 result act=%0d exp=%0d", result, e.res);
                end
                total++;
                if (cyc - e.t0 != e.lat) begin
                    bad++;
                    $display("FAIL R8 latency act=%0d exp=%0d", cyc - e.t0, e.lat);
                end
            end
        end
    end

    task automatic report;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic op(input logic [1:0] b, input logic sp, input logic [3:0] st,
                      input logic [15:0] mp, input logic [15:0] spp,
                      input logic poke, input string tag);
        logic fm, fs, unc;
        int   exp_w [$];
        exp_t e;
        int   lat;
        int   mis;
        int   first;
        fm  = !sp && (st[3:2] == 2'b01);
        fs  = (st[1:0] == 2'b01);
        unc = (!sp && st[3]) || st[1];
        if (fm) begin
            int a;
            a = int'(b) * 256 + ((int'(mp) >> 4) & 255);
            exp_w.push_back(a);
            exp_mem[a] = exp_mem[a] ^ (16'h1 << mp[3:0]);
        end
        if (fs) begin
            int a;
            a = 1024 + int'(b) * 8 + ((int'(spp) >> 4) & 7);
            exp_w.push_back(a);
            exp_mem[a] = exp_mem[a] ^ (16'h1 << spp[3:0]);
        end
        lat   = 1 + 2 * (int'(fm) + int'(fs));
        e.res = unc ? 2'b10 : ((fm || fs) ? 2'b01 : 2'b00);
        e.lat = lat;
        @(negedge clk);
        buf_sel = b; spare_only = sp; ecc_stat = st; main_pos = mp; spare_pos = spp;
        start = 1'b1;
        e.t0 = cyc;
        sb.push_back(e);
        @(negedge clk);
        if (poke) begin
            // R10: fresh request while busy must be dropped.
            ecc_stat = 4'b0101; main_pos = 16'h0010; spare_pos = 16'h0011; buf_sel = ~b;
            spare_only = 1'b0;
            @(negedge clk);
            start = 1'b0;
            repeat (lat + 1) @(negedge clk);
        end else begin
            start = 1'b0;
            repeat (lat + 2) @(negedge clk);
        end
        total++;
        if (wlog.size() != exp_w.size()) begin
            bad++;
            $display("FAIL %s write count act=%0d exp=%0d", tag, wlog.size(), exp_w.size());
        end else begin
            for (int i = 0; i < exp_w.size(); i++) begin
                if (wlog[i] != exp_w[i]) begin
                    bad++;
                    $display("FAIL %s write order/addr #%0d act=%0d exp=%0d", tag, i, wlog[i], exp_w[i]);
                    break;
                end
            end
        end
        wlog.delete();
        mis = 0; first = -1;
        for (int i = 0; i < WORDS; i++) begin
            if (mem[i] !== exp_mem[i]) begin
                mis++;
                if (first < 0) first = i;
            end
        end
        total++;
        if (mis != 0) begin
            bad++;
            $display("FAIL %s buffer word %0d act=%h exp=%h", tag, first, mem[first], exp_mem[first]);
        end
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i]     = 16'(i * 40503) ^ 16'h5a5a;
            exp_mem[i] = 16'(i * 40503) ^ 16'h5a5a;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (done || busy || ram_rd || ram_wr) begin
            bad++;
            $display("FAIL R1 reset outputs act=%b%b%b%b exp=0000", done, busy, ram_rd, ram_wr);
        end
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (done || busy || ram_rd || ram_wr) begin
            bad++;
            $display("FAIL R1 idle outputs act=%b%b%b%b exp=0000", done, busy, ram_rd, ram_wr);
        end

        op(2'd2, 1'b0, 4'b0000, 16'h0123, 16'h0045, 1'b0, "R2");  // clean
        op(2'd1, 1'b0, 4'b0100, 16'h0375, 16'h0000, 1'b0, "R3");  // main single
        op(2'd3, 1'b0, 4'b0001, 16'h0000, 16'h004F, 1'b0, "R3");  // spare single, bit 15
        op(2'd0, 1'b0, 4'b0101, 16'h0FF0, 16'h007A, 1'b0, "R5");  // both, slot ends
        op(2'd2, 1'b0, 4'b1001, 16'h0111, 16'h0023, 1'b0, "R6");  // main fatal, spare fixed
        op(2'd1, 1'b0, 4'b1010, 16'h0111, 16'h0023, 1'b0, "R6");  // both fatal
        op(2'd1, 1'b0, 4'b1100, 16'h0111, 16'h0023, 1'b0, "R2");  // code 11 = fatal
        op(2'd3, 1'b1, 4'b0100, 16'h0222, 16'h0010, 1'b0, "R7");  // main ignored
        op(2'd3, 1'b1, 4'b1001, 16'h0222, 16'h0036, 1'b0, "R7");  // fatal main ignored
        op(2'd0, 1'b0, 4'b0100, 16'h0482, 16'h0000, 1'b1, "R10"); // start while busy
        op(2'd3, 1'b0, 4'b0101, 16'hF123, 16'hFFF8, 1'b0, "R3");  // stray high bits
        op(2'd1, 1'b0, 4'b0100, 16'h0375, 16'h0000, 1'b0, "R4");  // same word back
        op(2'd0, 1'b0, 4'b0000, 16'h0000, 16'h0000, 1'b1, "R10"); // clean with poke

        repeat (4) @(negedge clk);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R8 missing done act=%0d exp=0", sb.size());
        end
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        report();
        $finish;
    end

endmodule